// File: doc/BRIEF.md
# Range-Based Memory Access Guard

This block watches a stream of bus accesses and reports those that the current protection setup forbids. Software programs six address windows and one privilege word through a simple write port. Each window is a naturally aligned power-of-two region, from 512 bytes up to 2 MB. It is described by base address bits and a five-bit size code. The privilege word grants read and write rights per window. It also holds a fallback read right and a fallback write right, which apply to addresses outside every window, as well as an enable bit and a test bit.

Every access is given as an address and a direction flag with a valid strobe. One clock later the guard raises a one-cycle read-violation or write-violation pulse if the access was refused, and it captures the offending address in a violation register that holds until the next refusal. The block only reports. Stopping the access is left to the bus fabric.

Operation is governed by a three-state mode machine. The states are OFF (checking disabled), GUARD (normal checking) and TEST (every access is reported). The mode moves on each write of the privilege word. The transition is to OFF when the enable bit is clear, to GUARD when enable is set and test is clear, and to TEST when both are set. Any state can reach any other state through a single privilege write.

Top module: `mguard`

## Requirements
- R1: After reset both violation pulses are low, the violation address is zero, all windows and permissions are zero and the mode is OFF.
- R2: A configuration write with selector 0 to 5 loads that window and selector 6 loads the privilege word; selector 7 changes nothing; a write takes effect for accesses from the following cycle.
- R3: Window data bits 31:9 hold the base and bits 4:0 hold the size code c; an address lies in the window when its bits 31:c equal the base bits 31:c, so the window covers 2^c bytes aligned to its size.
- R4: A size code below 9 acts as 9 (512 bytes) and a code above 21 acts as 21 (2 MB).
- R5: Privilege bits 0 to 5 grant write and bits 10 to 15 grant read for windows 0 to 5; an access is allowed when any window containing it grants the needed right.
- R6: Global write (privilege bit 9) and global read (bit 19) decide only accesses that fall in no window; a matching window without the right refuses even if the global right is set.
- R7: With enable (privilege bit 31) clear, no violation is raised and the violation address holds.
- R8: With enable and test (bit 30) both set, every valid access is reported as a violation.
- R9: A refused read raises the read pulse, and a refused write raises the write pulse, for exactly one cycle in the cycle after the access; the two pulses are never high together; the violation address takes the access address in that same cycle and is otherwise held.
- R10: Nothing is checked while the access valid strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target: 0-5 window, 6 privilege word |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_wr | input | 1 | Access direction: 1 write, 0 read |
| acc_addr | input | 32 | Access byte address |
| viol_addr | output | 32 | Address of the most recent refused access |
| rd_viol_irq | output | 1 | One-cycle pulse for a refused read |
| wr_viol_irq | output | 1 | One-cycle pulse for a refused write |

## Verification
Directed accesses sit on the last byte of a window and on the first byte past it. This separates a correct mask from one that is off by one. Size codes 3 and 31 are used to show the clamping at both ends of the size range. Further cases cover a window with the right missing while the global right is set, a window holding only the opposite right, and overlapping windows. Together they tell the per-window grant apart from the global fallback. Random windows with random size codes and random rights are mixed with random addresses, some near the window bases, and each result is checked against a bench model. The OFF, TEST and reserved-selector cases show that the mode machine and the write decode, rather than the permissions, decide the outcome.

// File: rtl/mguard_pkg.sv
package mguard_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_GUARD = 2'd1,
        MODE_TEST  = 2'd2
    } guard_mode_e;

    // privilege word field positions (decoded by software, so fixed)
    localparam int PRIV_WR_LSB  = 0;
    localparam int PRIV_GWR_BIT = 9;
    localparam int PRIV_RD_LSB  = 10;
    localparam int PRIV_GRD_BIT = 19;
    localparam int PRIV_TST_BIT = 30;
    localparam int PRIV_EN_BIT  = 31;
endpackage

// File: rtl/mguard_window.sv
module mguard_window #(
    parameter int DW       = 32,
    parameter int MIN_CODE = 9,
    parameter int MAX_CODE = 21,
    parameter int CODE_W   = 5
) (
    input  logic [DW-1:MIN_CODE] base,
    input  logic [CODE_W-1:0]    code,
    input  logic [DW-1:0]        addr,
    output logic                 hit
);
    logic [CODE_W-1:0] eff_code;
    logic [DW-1:0]     keep_mask;
    logic [DW-1:0]     base_full;

    always_comb begin
        if (code < CODE_W'(MIN_CODE))
            eff_code = CODE_W'(MIN_CODE);
        else if (code > CODE_W'(MAX_CODE))
            eff_code = CODE_W'(MAX_CODE);
        else
            eff_code = code;
        keep_mask = {DW{1'b1}} << eff_code;
        base_full = {base, {MIN_CODE{1'b0}}};
        hit       = ((addr ^ base_full) & keep_mask) == '0;
    end
endmodule

// File: rtl/mguard_decide.sv
module mguard_decide #(
    parameter int NRANGE = 6
) (
    input  logic [NRANGE-1:0] hit,
    input  logic [NRANGE-1:0] rperm,
    input  logic [NRANGE-1:0] wperm,
    input  logic              grd,
    input  logic              gwr,
    input  logic              is_wr,
    output logic              allow
);
    logic [NRANGE-1:0] need;
    logic              any_hit;

    always_comb begin
        need    = is_wr ? wperm : rperm;
        any_hit = |hit;
        if (any_hit)
            allow = |(hit & need);
        else
            allow = is_wr ? gwr : grd;
    end
endmodule

// File: rtl/mguard.sv
module mguard
    import mguard_pkg::*;
#(
    parameter int NRANGE   = 6,
    parameter int DW       = 32,
    parameter int MIN_CODE = 9,
    parameter int MAX_CODE = 21,
    parameter int CODE_W   = 5,
    parameter int SEL_W    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    input  logic          acc_valid,
    input  logic          acc_wr,
    input  logic [31:0]   acc_addr,
    output logic [31:0]   viol_addr,
    output logic          rd_viol_irq,
    output logic          wr_viol_irq
);
    localparam logic [SEL_W-1:0] PRIV_SEL = SEL_W'(NRANGE);

    logic [DW-1:MIN_CODE] base_q [NRANGE];
    logic [CODE_W-1:0]    code_q [NRANGE];
    logic [NRANGE-1:0]    hit;
    logic [NRANGE-1:0]    wperm_q, rperm_q;
    logic                 gwr_q, grd_q;
    logic                 allow, viol;
    logic                 priv_wr;
    logic                 unused_cfg;
    guard_mode_e          mode_q, mode_d;

    assign priv_wr    = cfg_we && (cfg_sel == PRIV_SEL);
    assign unused_cfg = ^cfg_wdata;

    // per-window storage and address comparator
    for (genvar g = 0; g < NRANGE; g++) begin : g_win
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[g] <= '0;
                code_q[g] <= '0;
            end else if (cfg_we && (cfg_sel == SEL_W'(g))) begin
                base_q[g] <= cfg_wdata[DW-1:MIN_CODE];
                code_q[g] <= cfg_wdata[CODE_W-1:0];
            end
        end

        mguard_window #(
            .DW(DW), .MIN_CODE(MIN_CODE), .MAX_CODE(MAX_CODE), .CODE_W(CODE_W)
        ) u_win (
            .base(base_q[g]),
            .code(code_q[g]),
            .addr(acc_addr),
            .hit (hit[g])
        );
    end

    // permission fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wperm_q <= '0;
            rperm_q <= '0;
            gwr_q   <= 1'b0;
            grd_q   <= 1'b0;
        end else if (priv_wr) begin
            wperm_q <= cfg_wdata[PRIV_WR_LSB +: NRANGE];
            rperm_q <= cfg_wdata[PRIV_RD_LSB +: NRANGE];
            gwr_q   <= cfg_wdata[PRIV_GWR_BIT];
            grd_q   <= cfg_wdata[PRIV_GRD_BIT];
        end
    end

    mguard_decide #(.NRANGE(NRANGE)) u_decide (
        .hit  (hit),
        .rperm(rperm_q),
        .wperm(wperm_q),
        .grd  (grd_q),
        .gwr  (gwr_q),
        .is_wr(acc_wr),
        .allow(allow)
    );

    // mode machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_OFF;
        else        mode_q <= mode_d;
    end

    // mode machine: next state
    always_comb begin
        mode_d = mode_q;
        if (priv_wr) begin
            unique case ({cfg_wdata[PRIV_EN_BIT], cfg_wdata[PRIV_TST_BIT]})
                2'b10:   mode_d = MODE_GUARD;
                2'b11:   mode_d = MODE_TEST;
                default: mode_d = MODE_OFF;
            endcase
        end
    end

    // mode machine: violation decision
    always_comb begin
        unique case (mode_q)
            MODE_OFF:   viol = 1'b0;
            MODE_GUARD: viol = acc_valid && !allow;
            MODE_TEST:  viol = acc_valid;
            default:    viol = 1'b0;
        endcase
    end

    // registered report
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_viol_irq <= 1'b0;
            wr_viol_irq <= 1'b0;
            viol_addr   <= '0;
        end else begin
            rd_viol_irq <= viol && !acc_wr;
            wr_viol_irq <= viol && acc_wr;
            if (viol) viol_addr <= acc_addr;
        end
    end
endmodule

// File: rtl/mguard_chk.sv
module mguard_chk
    import mguard_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_wr,
    input logic [31:0] acc_addr,
    input logic [31:0] viol_addr,
    input logic        rd_viol_irq,
    input logic        wr_viol_irq,
    input guard_mode_e mode
);
    assert_irq_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_viol_irq, wr_viol_irq}));

    assert_rd_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_viol_irq |-> $past(acc_valid && !acc_wr));

    assert_wr_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_viol_irq |-> $past(acc_valid && acc_wr));

    assert_addr_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_viol_irq || wr_viol_irq) |-> (viol_addr == $past(acc_addr)));

    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_viol_irq || wr_viol_irq) |-> $stable(viol_addr));

    assert_off_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode == MODE_OFF) |-> !(rd_viol_irq || wr_viol_irq));

    assert_test_reports_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TEST && acc_valid) |=> (rd_viol_irq || wr_viol_irq));
endmodule

bind mguard mguard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_wr     (acc_wr),
    .acc_addr   (acc_addr),
    .viol_addr  (viol_addr),
    .rd_viol_irq(rd_viol_irq),
    .wr_viol_irq(wr_viol_irq),
    .mode       (mode_q)
);

// File: tb/tb_mguard.sv
`timescale 1ns/1ps
module tb_mguard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic        acc_wr = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [31:0] viol_addr;
    logic        rd_viol_irq, wr_viol_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model of the programmed state
    logic [31:0] m_base [6];
    int          m_code [6];
    logic [5:0]  m_wp, m_rp;
    bit          m_gw, m_gr, m_en, m_tst;
    logic [31:0] m_viol;

    always #2 clk = ~clk;

    mguard dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .viol_addr(viol_addr),
        .rd_viol_irq(rd_viol_irq), .wr_viol_irq(wr_viol_irq)
    );

    function automatic bit model_refuse(logic [31:0] a, bit w);
        bit any_hit = 1'b0;
        bit granted = 1'b0;
        if (!m_en) return 1'b0;
        if (m_tst) return 1'b1;
        for (int i = 0; i < 6; i++) begin
            int c = (m_code[i] < 9) ? 9 : (m_code[i] > 21) ? 21 : m_code[i];
            if ((a >> c) == (m_base[i] >> c)) begin
                any_hit = 1'b1;
                if (w ? m_wp[i] : m_rp[i]) granted = 1'b1;
            end
        end
        if (!any_hit) granted = w ? m_gw : m_gr;
        return !granted;
    endfunction

    task automatic check(string tag, bit exp_r, bit exp_w, logic [31:0] exp_a);
        n_chk++;
        if (rd_viol_irq !== exp_r || wr_viol_irq !== exp_w || viol_addr !== exp_a) begin
            n_fail++;
            $display("FAIL %s: rd/wr/addr got %0b/%0b/%h expected %0b/%0b/%h",
                     tag, rd_viol_irq, wr_viol_irq, viol_addr, exp_r, exp_w, exp_a);
        end
    endtask

    task automatic cfg_write(logic [2:0] sel, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel < 6) begin
            m_base[sel] = d & 32'hFFFF_FE00;
            m_code[sel] = int'(d[4:0]);
        end else if (sel == 6) begin
            m_wp = d[5:0]; m_rp = d[15:10];
            m_gw = d[9];   m_gr = d[19];
            m_en = d[31];  m_tst = d[30];
        end
    endtask

    // access with explicit expectation; checks the cycle after the access
    task automatic access(logic [31:0] a, bit w, bit exp_refuse, string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_wr = w; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0;
        if (exp_refuse) m_viol = a;
        check(tag, exp_refuse && !w, exp_refuse && w, m_viol);
    endtask

    task automatic idle_addr(logic [31:0] a, bit w, string tag);
        @(negedge clk);
        acc_valid = 1'b0; acc_wr = w; acc_addr = a;
        @(negedge clk);
        check(tag, 1'b0, 1'b0, m_viol);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 6; i++) begin m_base[i] = '0; m_code[i] = 0; end
        m_wp = '0; m_rp = '0; m_gw = 0; m_gr = 0; m_en = 0; m_tst = 0; m_viol = '0;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", 1'b0, 1'b0, 32'h0);
        rst_n = 1'b1;
        access(32'h1234_5678, 1'b1, 1'b0, "R1 mode off after reset");

        // guard on, window 0: 4 KB at 0x1000_0000, no rights
        cfg_write(3'd0, 32'h1000_000C);
        cfg_write(3'd6, 32'h8000_0000);
        access(32'h1000_0FFF, 1'b0, 1'b1, "R3 last byte inside, no read right");
        access(32'h1000_1000, 1'b1, 1'b1, "R3 first byte past window, no global");
        cfg_write(3'd6, 32'h8000_0001);
        access(32'h1000_0000, 1'b1, 1'b0, "R5 window write right");
        access(32'h1000_0004, 1'b0, 1'b1, "R5 write right does not grant read");
        cfg_write(3'd6, 32'h8008_0201);
        access(32'h1000_2000, 1'b1, 1'b0, "R6 global write outside windows");
        access(32'h1000_0010, 1'b0, 1'b1, "R6 global read ignored in window");

        // clamping of size codes
        cfg_write(3'd1, 32'h2000_0003);
        cfg_write(3'd6, 32'h8000_0800);
        access(32'h2000_01FF, 1'b0, 1'b0, "R4 small code acts as 512 B inside");
        access(32'h2000_0200, 1'b0, 1'b1, "R4 small code acts as 512 B past");
        cfg_write(3'd1, 32'h2000_001F);
        access(32'h201F_FFFF, 1'b0, 1'b0, "R4 large code acts as 2 MB inside");
        access(32'h2020_0000, 1'b0, 1'b1, "R4 large code acts as 2 MB past");

        // overlap: window 2 inside window 1, only window 2 grants write
        cfg_write(3'd2, 32'h2000_1009);
        cfg_write(3'd6, 32'h8000_0004);
        access(32'h2000_1004, 1'b1, 1'b0, "R5 any matching window grants");
        access(32'h2000_2004, 1'b1, 1'b1, "R5 only ungranting window matches");

        // reserved selector has no effect
        cfg_write(3'd7, 32'h0000_0000);
        access(32'h2000_2008, 1'b1, 1'b1, "R2 selector 7 ignored");

        // test mode
        cfg_write(3'd6, 32'hC000_0004);
        access(32'h2000_1008, 1'b1, 1'b1, "R8 test mode reports allowed write");
        access(32'h0000_0040, 1'b0, 1'b1, "R8 test mode reports read");

        // valid low
        idle_addr(32'h0BAD_0000, 1'b0, "R10 no check without valid");

        // disabled
        cfg_write(3'd6, 32'h0000_0000);
        access(32'h2000_2000, 1'b1, 1'b0, "R7 disabled raises nothing, address held");

        // random phase
        for (int blk = 0; blk < 8; blk++) begin
            for (int i = 0; i < 6; i++)
                cfg_write(3'(i), (32'h4000_0000 | ($urandom & 32'h00FF_FE00)) | ($urandom & 32'h1F));
            cfg_write(3'd6, 32'h8000_0000 | ($urandom & 32'h000F_FE3F));
            for (int k = 0; k < 60; k++) begin
                logic [31:0] a;
                bit w = 1'($urandom);
                if ($urandom % 2)
                    a = 32'h4000_0000 | ($urandom & 32'h00FF_FFFF);
                else
                    a = m_base[$urandom % 6] + ($urandom % 32'h0000_4000) - 32'h100;
                access(a, w, model_refuse(a, w), "R3 R5 R6 random access");
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule